// File: doc/BRIEF.md
# DMA Descriptor Consistency Checker

This block sits beside one DMA channel and inspects the transfer descriptor loaded into that channel before the channel is allowed to run. On a check strobe it tests the source and destination addresses and the signed per-access offsets for alignment against their transfer sizes. It also tests the byte count against both sizes, and the iteration count and link flags for consistency. It records the single highest-ranked inconsistency as a cause bit. A separate reload strobe checks the next-descriptor pointer of a scatter/gather chain. Two external inputs report bus faults on source reads and destination writes.

Every cause bit is sticky, and a summary bit tracks whether any cause is present. Software clears the whole word by writing one to the summary bit. An optional error interrupt follows the summary bit. The channel sequencer starts a transfer only when the grant pulse that follows a check strobe is high, so a channel with a pending error cannot start. The transfer size is a 3-bit code that selects 2^code bytes, from 1 up to 128.

Top module: `dma_desc_checker`

## Requirements
- R1: A size code c means 2^c bytes (0=1 ... 7=128). On a check, a source address with any of its low c bits set records bit 7 (source size), and a destination address misaligned to the destination size records bit 5.
- R2: On a check, a signed source offset that is not a multiple of the source size records bit 6, and the same rule for the destination offset records bit 4. The test is on the two's complement value.
- R3: On a check, bit 3 records when the 30-bit byte count is not a multiple of both sizes, when the 15-bit current iteration count is zero, or when the current and beginning link flags differ.
- R4: One check records at most one configuration cause, ranked bit 3 > bit 7 > bit 6 > bit 5 > bit 4.
- R5: A reload strobe with scatter/gather enabled records bit 2 if the next-descriptor pointer is not a multiple of 32. With scatter/gather disabled, the strobe has no effect.
- R6: A high destination bus error input records bit 0, and a high source bus error input records bit 1, in any cycle.
- R7: Bit 31 is one exactly when any cause bit is one. Bits 30..8 always read zero.
- R8: Cause bits stay set until a clear write with the summary data bit at one, which zeroes the word on the next cycle. A clear write with that data bit at zero changes nothing.
- R9: A cause detected in the same cycle as a clear write is kept after the clear.
- R10: The error interrupt is high exactly when the interrupt enable is high and bit 31 is set.
- R11: The start grant is high for one cycle, the cycle after a check strobe, only if the status word after that check is all zero.
- R12: A check and a reload strobe in the same cycle both record their causes.
- R13: Reset zeroes the status word, the interrupt and the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_strobe | input | 1 | Check the loaded descriptor |
| sg_strobe | input | 1 | Scatter/gather reload point reached |
| src_addr | input | 32 | Source address |
| dst_addr | input | 32 | Destination address |
| src_off | input | 16 | Signed source offset |
| dst_off | input | 16 | Signed destination offset |
| src_size | input | 3 | Source size code |
| dst_size | input | 3 | Destination size code |
| byte_cnt | input | 30 | Bytes per request |
| cur_iter | input | 15 | Current iteration count |
| cur_link | input | 1 | Link flag of current count |
| beg_link | input | 1 | Link flag of beginning count |
| sg_ptr | input | 32 | Next-descriptor pointer |
| sg_enable | input | 1 | Scatter/gather enabled |
| dst_bus_err | input | 1 | Destination write bus fault |
| src_bus_err | input | 1 | Source read bus fault |
| clr_write | input | 1 | Status write strobe |
| clr_sum_bit | input | 1 | Written value of bit 31 |
| err_int_en | input | 1 | Error interrupt enable |
| err_status | output | 32 | Sticky status word |
| err_irq | output | 1 | Error interrupt request |
| start_grant | output | 1 | Channel may start |

## Verification
Three pairs of events can fall in the same cycle. A descriptor check and a scatter/gather reload can coincide. A clear write can coincide with a freshly reported bus fault. A check can coincide with a pending error from an earlier cycle. The bench drives each pair with both strobes high on one edge. It judges the result by comparing the whole status word and the grant against values it builds from the rules: both causes present for R12, only the new cause surviving the clear for R9, and no grant while an older cause remains for R11.

// File: rtl/dma_chk_pkg.sv
// Package: shared constants and helpers for the descriptor checker.
// Assumes size codes are 3 bits wide and select 2^code bytes.
package dma_chk_pkg;
    localparam int SIZE_CODE_W = 3;
    localparam int MAX_LOG2    = 7;
    localparam int CAUSE_W     = 8;

    // Cause bit positions inside the status word.
    localparam int BIT_DBUS  = 0;
    localparam int BIT_SBUS  = 1;
    localparam int BIT_SG    = 2;
    localparam int BIT_CNT   = 3;
    localparam int BIT_DOFF  = 4;
    localparam int BIT_DADDR = 5;
    localparam int BIT_SOFF  = 6;
    localparam int BIT_SADDR = 7;

    typedef logic [SIZE_CODE_W-1:0] size_code_t;

    // Raw configuration findings of one check, before ranking.
    typedef struct packed {
        logic cnt;
        logic saddr;
        logic soff;
        logic daddr;
        logic doff;
    } cfg_find_t;

    // Low-bit mask for a size code: 2^code - 1.
    function automatic logic [MAX_LOG2-1:0] size_mask(input size_code_t code);
        logic [MAX_LOG2:0] one_hot;
        one_hot = (MAX_LOG2+1)'(1) << code;
        return MAX_LOG2'(one_hot - (MAX_LOG2+1)'(1));
    endfunction
endpackage

// File: rtl/dma_align_unit.sv
// Module: tests one value for alignment to a transfer size.
// Assumes W >= MAX_LOG2; for signed values the two's complement bits are tested.
module dma_align_unit
    import dma_chk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  size_code_t   code,
    output logic         misaligned
);
    logic [W-1:0] mask_w;

    // Widen the size mask and test the low bits of the value.
    always_comb begin
        mask_w     = W'(size_mask(code));
        misaligned = |(value & mask_w);
    end
endmodule

// File: rtl/dma_count_check.sv
// Module: byte count, iteration count and link flag consistency test.
// Assumes a byte count is legal when it is a multiple of the larger size.
module dma_count_check
    import dma_chk_pkg::*;
#(
    parameter int NB_W = 30,
    parameter int IT_W = 15
) (
    input  logic [NB_W-1:0] byte_cnt,
    input  size_code_t      src_size,
    input  size_code_t      dst_size,
    input  logic [IT_W-1:0] cur_iter,
    input  logic            cur_link,
    input  logic            beg_link,
    output logic            bad
);
    size_code_t   big_code;
    logic [NB_W-1:0] mask_w;

    // The larger size dominates: a multiple of it is a multiple of both.
    always_comb begin
        big_code = (src_size > dst_size) ? src_size : dst_size;
        mask_w   = NB_W'(size_mask(big_code));
        bad      = (|(byte_cnt & mask_w)) || (cur_iter == '0) || (cur_link != beg_link);
    end
endmodule

// File: rtl/dma_cause_select.sv
// Module: ranks raw findings and keeps only the highest one.
// Rank: count, source address, source offset, destination address, destination offset.
module dma_cause_select
    import dma_chk_pkg::*;
(
    input  cfg_find_t raw,
    output cfg_find_t pick
);
    // Fixed-priority pick of one finding.
    always_comb begin
        pick = '0;
        if (raw.cnt)        pick.cnt   = 1'b1;
        else if (raw.saddr) pick.saddr = 1'b1;
        else if (raw.soff)  pick.soff  = 1'b1;
        else if (raw.daddr) pick.daddr = 1'b1;
        else if (raw.doff)  pick.doff  = 1'b1;
    end
endmodule

// File: rtl/dma_err_status.sv
// Module: sticky status word with summary bit and the start grant.
// Assumes a clear acts on the old word, and new causes are OR-ed in after it.
module dma_err_status
    import dma_chk_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_causes,
    input  logic               clear,
    input  logic               chk_strobe,
    output logic [STAT_W-1:0]  status,
    output logic               start_grant
);
    localparam int PAD_W = STAT_W - CAUSE_W - 1;

    logic [CAUSE_W-1:0] causes_q;
    logic [CAUSE_W-1:0] causes_d;

    // Next cause vector: drop on clear, then accumulate new findings.
    always_comb begin
        causes_d = (clear ? '0 : causes_q) | set_causes;
    end

    // Cause register and grant, with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            causes_q    <= '0;
            start_grant <= 1'b0;
        end else begin
            causes_q    <= causes_d;
            start_grant <= chk_strobe && (causes_d == '0);
        end
    end

    // Assemble the visible word.
    always_comb begin
        status = {(|causes_q), {PAD_W{1'b0}}, causes_q};
    end
endmodule

// File: rtl/dma_desc_checker.sv
// Module: top of the descriptor consistency checker.
// Assumes descriptor fields are stable in the cycle of each strobe.
module dma_desc_checker
    import dma_chk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int NB_W       = 30,
    parameter int IT_W       = 15,
    parameter int STAT_W     = 32,
    parameter int SG_ALIGN_L = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_strobe,
    input  logic              sg_strobe,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [OFF_W-1:0]  dst_off,
    input  logic [2:0]        src_size,
    input  logic [2:0]        dst_size,
    input  logic [NB_W-1:0]   byte_cnt,
    input  logic [IT_W-1:0]   cur_iter,
    input  logic              cur_link,
    input  logic              beg_link,
    input  logic [ADDR_W-1:0] sg_ptr,
    input  logic              sg_enable,
    input  logic              dst_bus_err,
    input  logic              src_bus_err,
    input  logic              clr_write,
    input  logic              clr_sum_bit,
    input  logic              err_int_en,
    output logic [STAT_W-1:0] err_status,
    output logic              err_irq,
    output logic              start_grant
);
    localparam int N_ALIGN = 4;
    localparam logic [ADDR_W-1:0] SG_MASK = ADDR_W'((1 << SG_ALIGN_L) - 1);

    logic [N_ALIGN-1:0][ADDR_W-1:0] al_val;
    size_code_t [N_ALIGN-1:0]       al_code;
    logic [N_ALIGN-1:0]             al_bad;
    logic                           cnt_bad;
    cfg_find_t                      raw_find;
    cfg_find_t                      pick_find;
    logic                           sg_bad;
    logic [CAUSE_W-1:0]             set_causes;

    // Route the four aligned fields: 0 src addr, 1 src off, 2 dst addr, 3 dst off.
    always_comb begin
        al_val[0]  = src_addr;
        al_val[1]  = ADDR_W'($signed(src_off));
        al_val[2]  = dst_addr;
        al_val[3]  = ADDR_W'($signed(dst_off));
        al_code[0] = src_size;
        al_code[1] = src_size;
        al_code[2] = dst_size;
        al_code[3] = dst_size;
    end

    for (genvar gi = 0; gi < N_ALIGN; gi++) begin : g_align
        dma_align_unit #(.W(ADDR_W)) align_i (
            .value      (al_val[gi]),
            .code       (al_code[gi]),
            .misaligned (al_bad[gi])
        );
    end

    dma_count_check #(.NB_W(NB_W), .IT_W(IT_W)) count_i (
        .byte_cnt (byte_cnt),
        .src_size (src_size),
        .dst_size (dst_size),
        .cur_iter (cur_iter),
        .cur_link (cur_link),
        .beg_link (beg_link),
        .bad      (cnt_bad)
    );

    // Collect raw findings for ranking.
    always_comb begin
        raw_find.cnt   = cnt_bad;
        raw_find.saddr = al_bad[0];
        raw_find.soff  = al_bad[1];
        raw_find.daddr = al_bad[2];
        raw_find.doff  = al_bad[3];
    end

    dma_cause_select select_i (
        .raw  (raw_find),
        .pick (pick_find)
    );

    // Scatter/gather pointer boundary test.
    always_comb begin
        sg_bad = |(sg_ptr & SG_MASK);
    end

    // Build the per-cycle set vector from strobes and fault inputs.
    always_comb begin
        set_causes            = '0;
        set_causes[BIT_DBUS]  = dst_bus_err;
        set_causes[BIT_SBUS]  = src_bus_err;
        set_causes[BIT_SG]    = sg_strobe && sg_enable && sg_bad;
        set_causes[BIT_CNT]   = chk_strobe && pick_find.cnt;
        set_causes[BIT_DOFF]  = chk_strobe && pick_find.doff;
        set_causes[BIT_DADDR] = chk_strobe && pick_find.daddr;
        set_causes[BIT_SOFF]  = chk_strobe && pick_find.soff;
        set_causes[BIT_SADDR] = chk_strobe && pick_find.saddr;
    end

    dma_err_status #(.STAT_W(STAT_W)) status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_causes  (set_causes),
        .clear       (clr_write && clr_sum_bit),
        .chk_strobe  (chk_strobe),
        .status      (err_status),
        .start_grant (start_grant)
    );

    // Interrupt follows the summary bit when enabled.
    always_comb begin
        err_irq = err_int_en && err_status[STAT_W-1];
    end
endmodule

// File: rtl/dma_desc_checker_sva.sv
// Checker: temporal properties of the descriptor checker, bound to the top.
module dma_desc_checker_sva #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sg_strobe,
    input logic              clr_write,
    input logic              clr_sum_bit,
    input logic              err_int_en,
    input logic [STAT_W-1:0] err_status,
    input logic              err_irq,
    input logic              start_grant
);
    // R8: without a clearing write, no set bit drops.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_write && clr_sum_bit) |=> ((err_status & $past(err_status)) == $past(err_status)));

    // R7: summary matches the cause bits and the pad stays zero.
    a_r7_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status[STAT_W-1] == (|err_status[7:0])) && (err_status[STAT_W-2:8] == '0));

    // R10: the interrupt needs both its enable and a recorded error.
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (err_int_en && err_status[STAT_W-1]));

    // R4: a single cycle adds at most one configuration cause.
    a_r4_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(err_status[7:3] & ~$past(err_status[7:3])) <= 1));

    // R11: a grant never coexists with a recorded error.
    a_r11_grant_clean: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant |-> !err_status[STAT_W-1]);

    // R5: the pointer cause only rises after a reload strobe.
    a_r5_sg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sg_strobe |=> !(err_status[2] && !$past(err_status[2])));

    // R13: reset leaves everything idle.
    a_r13_reset: assert property (@(posedge clk)
        !rst_n |=> (err_status == '0) && !start_grant);
endmodule

bind dma_desc_checker dma_desc_checker_sva #(.STAT_W(STAT_W)) sva_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sg_strobe   (sg_strobe),
    .clr_write   (clr_write),
    .clr_sum_bit (clr_sum_bit),
    .err_int_en  (err_int_en),
    .err_status  (err_status),
    .err_irq     (err_irq),
    .start_grant (start_grant)
);

// File: tb/dma_desc_checker_tb_top.sv
module dma_desc_checker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic chk_strobe = 0, sg_strobe = 0, cur_link = 0, beg_link = 0, sg_enable = 0;
    logic dst_bus_err = 0, src_bus_err = 0, clr_write = 0, clr_sum_bit = 0, err_int_en = 0;
    logic [31:0] src_addr = 0, dst_addr = 0, sg_ptr = 0;
    logic [15:0] src_off = 0, dst_off = 0;
    logic [2:0]  src_size = 0, dst_size = 0;
    logic [29:0] byte_cnt = 30'd128;
    logic [14:0] cur_iter = 15'd1;
    logic [31:0] err_status;
    logic        err_irq, start_grant;

    int total = 0;
    int bad = 0;

    dma_desc_checker dut_i (
        .clk(clk), .rst_n(rst_n), .chk_strobe(chk_strobe), .sg_strobe(sg_strobe),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_off(src_off), .dst_off(dst_off),
        .src_size(src_size), .dst_size(dst_size), .byte_cnt(byte_cnt), .cur_iter(cur_iter),
        .cur_link(cur_link), .beg_link(beg_link), .sg_ptr(sg_ptr), .sg_enable(sg_enable),
        .dst_bus_err(dst_bus_err), .src_bus_err(src_bus_err), .clr_write(clr_write),
        .clr_sum_bit(clr_sum_bit), .err_int_en(err_int_en), .err_status(err_status),
        .err_irq(err_irq), .start_grant(start_grant)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] with_sum(input logic [31:0] c);
        return (c == 0) ? 32'h0 : (c | 32'h8000_0000);
    endfunction

    // Expected single configuration cause from the requirement rules.
    function automatic logic [31:0] exp_cfg();
        int mx;
        logic cnt, sa, so, da, dof;
        mx  = (src_size > dst_size) ? src_size : dst_size;
        cnt = ((byte_cnt % (30'd1 << mx)) != 0) || (cur_iter == 0) || (cur_link != beg_link);
        sa  = (src_addr % (32'd1 << src_size)) != 0;
        da  = (dst_addr % (32'd1 << dst_size)) != 0;
        so  = (src_off & ((16'd1 << src_size) - 16'd1)) != 0;
        dof = (dst_off & ((16'd1 << dst_size) - 16'd1)) != 0;
        if (cnt) return 32'h08;
        if (sa)  return 32'h80;
        if (so)  return 32'h40;
        if (da)  return 32'h20;
        if (dof) return 32'h10;
        return 32'h0;
    endfunction

    task automatic clean_fields();
        src_addr = 0; dst_addr = 0; src_off = 0; dst_off = 0;
        src_size = 0; dst_size = 0; byte_cnt = 30'd128; cur_iter = 15'd1;
        cur_link = 0; beg_link = 0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr_write = 1; clr_sum_bit = 1;
        @(negedge clk); clr_write = 0; clr_sum_bit = 0;
    endtask

    task automatic do_check(input string tag);
        logic [31:0] e;
        e = with_sum(exp_cfg());
        @(negedge clk); chk_strobe = 1;
        @(negedge clk); chk_strobe = 0;
        check(tag, err_status, e);
        check({tag, " grant R11"}, {31'd0, start_grant}, {31'd0, e == 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R13 reset status", err_status, 32'h0);
        check("R13 reset irq/grant", {30'd0, err_irq, start_grant}, 32'h0);
        rst_n = 1;

        // R1: source and destination address sweeps over all sizes.
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 128; k++) begin
                clean_fields(); src_size = 3'(s); src_addr = 32'h1000_0000 + 32'(k);
                do_clear(); do_check("R1 src addr");
                clean_fields(); dst_size = 3'(s); dst_addr = 32'h2000_0000 + 32'(k);
                do_clear(); do_check("R1 dst addr");
            end
        end

        // R2: signed offset sweeps, including negative values.
        for (int s = 0; s < 8; s++) begin
            for (int k = -64; k < 64; k++) begin
                clean_fields(); src_size = 3'(s); src_off = 16'(k);
                do_clear(); do_check("R2 src off");
                clean_fields(); dst_size = 3'(s); dst_off = 16'(k);
                do_clear(); do_check("R2 dst off");
            end
        end

        // R3: byte count against every size pair.
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
                for (int n = 0; n < 64; n++) begin
                    clean_fields(); src_size = 3'(s); dst_size = 3'(d); byte_cnt = 30'(n * 3);
                    do_clear(); do_check("R3 byte count");
                end
            end
        end
        clean_fields(); cur_iter = 0; do_clear(); do_check("R3 zero iteration");
        clean_fields(); cur_iter = 15'h7fff; do_clear(); do_check("R3 max iteration");
        clean_fields(); cur_link = 1; do_clear(); do_check("R3 link mismatch");
        clean_fields(); cur_link = 1; beg_link = 1; do_clear(); do_check("R3 link match");

        // R4: several faults at once, only the top-ranked one recorded.
        clean_fields(); src_size = 2; dst_size = 2; src_addr = 1; src_off = 1; dst_addr = 2; dst_off = 3;
        do_clear(); do_check("R4 saddr wins");
        byte_cnt = 30'd5; do_clear(); do_check("R4 count wins");
        byte_cnt = 30'd128; src_addr = 0; do_clear(); do_check("R4 soff wins");
        src_off = 0; do_clear(); do_check("R4 daddr wins");
        dst_addr = 0; do_clear(); do_check("R4 doff wins");

        // R5: pointer boundary sweep, and disabled reload ignored.
        clean_fields();
        for (int k = 0; k < 64; k++) begin
            do_clear();
            sg_ptr = 32'h3000_0000 + 32'(k); sg_enable = 1;
            @(negedge clk); sg_strobe = 1;
            @(negedge clk); sg_strobe = 0;
            check("R5 sg pointer", err_status, with_sum((k % 32 != 0) ? 32'h4 : 32'h0));
        end
        do_clear(); sg_ptr = 32'h3; sg_enable = 0;
        @(negedge clk); sg_strobe = 1;
        @(negedge clk); sg_strobe = 0;
        check("R5 sg disabled ignored", err_status, 32'h0);

        // R6/R10: bus faults and interrupt enable.
        do_clear();
        @(negedge clk); dst_bus_err = 1;
        @(negedge clk); dst_bus_err = 0;
        check("R6 dst bus", err_status, 32'h8000_0001);
        check("R10 irq disabled", {31'd0, err_irq}, 32'd0);
        err_int_en = 1; #1;
        check("R10 irq enabled", {31'd0, err_irq}, 32'd1);
        @(negedge clk); src_bus_err = 1;
        @(negedge clk); src_bus_err = 0;
        check("R6 src bus", err_status, 32'h8000_0003);

        // R8/R11: sticky under a clean check, no grant while pending.
        @(negedge clk); chk_strobe = 1;
        @(negedge clk); chk_strobe = 0;
        check("R8 sticky after clean check", err_status, 32'h8000_0003);
        check("R11 grant blocked", {31'd0, start_grant}, 32'd0);
        @(negedge clk); clr_write = 1; clr_sum_bit = 0;
        @(negedge clk); clr_write = 0;
        check("R8 write zero ignored", err_status, 32'h8000_0003);
        do_clear();
        check("R8 cleared", err_status, 32'h0);
        check("R10 irq drops", {31'd0, err_irq}, 32'd0);
        err_int_en = 0;

        // R9: clear and new fault in the same cycle.
        @(negedge clk); dst_bus_err = 1;
        @(negedge clk); dst_bus_err = 0;
        @(negedge clk); clr_write = 1; clr_sum_bit = 1; src_bus_err = 1;
        @(negedge clk); clr_write = 0; clr_sum_bit = 0; src_bus_err = 0;
        check("R9 new cause survives clear", err_status, 32'h8000_0002);

        // R12: check and reload in the same cycle.
        do_clear();
        clean_fields(); cur_iter = 0; sg_enable = 1; sg_ptr = 32'h10;
        @(negedge clk); chk_strobe = 1; sg_strobe = 1;
        @(negedge clk); chk_strobe = 0; sg_strobe = 0;
        check("R12 both recorded", err_status, 32'h8000_000C);
        check("R12 no grant", {31'd0, start_grant}, 32'd0);
        do_clear(); clean_fields(); sg_ptr = 32'h40;
        @(negedge clk); chk_strobe = 1; sg_strobe = 1;
        @(negedge clk); chk_strobe = 0; sg_strobe = 0;
        check("R12 both clean grant R11", {err_status[31:1], start_grant}, 32'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule